// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is the programmable AND-OR core of a small registered-logic device. Twenty-two input signals enter the array. Each one is offered in true form and in complement form, which gives 44 columns. A fuse vector chooses which columns feed each of 132 product terms. The product terms are grouped into ten sum terms of unequal size. Each output also gets one product term that serves only as its output enable. Two more global product terms drive the shared asynchronous-reset line and the shared synchronous-preset line. The output macrocells that consume these signals sit outside this block.

The configuration is a single linear fuse vector of 5892 bits, loaded serially with the lowest address first. After the product-term fuses, the vector holds a mode-bit pair for each output and a 64-bit user signature. Software-side tooling reads individual fuses back by address. Once a protection flag is raised, the logic and mode fuses read back as zero, but the signature stays visible. The flag remains set until the next full load begins.

Top module: `sop_array`

## Requirements
- R1: After reset, every fuse is 1 (connected), so sum_out, oe_out, ar_term and sp_term are 0 and mode_bits is all ones. In this state load_done is 0 and rd_data of address 0 reads 1.
- R2: A pulse on load_start begins a load. Each later cycle with load_valid high shifts in load_bit, and the k-th accepted bit ends up at fuse address k. Cycles with load_valid low are skipped. load_done rises in the cycle after bit 5891 is taken and stays high. Once load_done is high, further valid bits are ignored.
- R3: Product term t uses fuses 44*t to 44*t+43. Fuse column 2k connects input k true and column 2k+1 connects input k inverted, and a fuse value of 1 means connected. The term is the AND of its connected columns. A term with every fuse at 1 is therefore 0, and a term with no fuse at 1 is 1.
- R4: The logic term counts per output, from output 0 to output 9, are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. sum_out[i] is the OR of output i's logic terms.
- R5: Term order is: term 0, then for each output in turn its enable term followed by its logic terms, then term 131. oe_out[i] is output i's enable term.
- R6: ar_term is product term 0 and sp_term is product term 131.
- R7: mode_bits[2i] is fuse 5808+2i and mode_bits[2i+1] is fuse 5809+2i.
- R8: With protection clear, rd_data shows fuse rd_addr combinationally. Addresses 5892 and above read 0.
- R9: After a pulse on sec_set, addresses 0 to 5827 read 0. Signature addresses 5828 to 5891 still read their fuses, and the array outputs are unaffected. The flag is sticky.
- R10: load_start clears the protection flag and load_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 22 | Array input signals |
| load_start | input | 1 | Begin a new configuration load |
| load_valid | input | 1 | load_bit is valid this cycle |
| load_bit | input | 1 | Serial fuse data, lowest address first |
| sec_set | input | 1 | Raise readback protection |
| rd_addr | input | 13 | Fuse readback address |
| load_done | output | 1 | Full fuse vector loaded |
| rd_data | output | 1 | Fuse value at rd_addr |
| sum_out | output | 10 | Sum terms, one per output |
| oe_out | output | 10 | Output-enable terms |
| ar_term | output | 1 | Global asynchronous-reset term |
| sp_term | output | 1 | Global synchronous-preset term |
| mode_bits | output | 20 | Mode bit pair per output |

## Verification
The bench targets the unequal term grouping with sparse random terms. A design that shifts a group boundary by one term, or mirrors the size list, gives the wrong sum or enable value on some outputs. It checks the polarity of the column pairs, because swapping true and complement inverts results whenever a single column is connected. It also checks that all-connected terms evaluate to 0, which a design that skips complement columns would violate. Readback is checked on both sides of the signature boundary while protected. Leaking logic fuses, or blanking the signature, shows up there. The last bit of a load and the extra bits after it are checked too: an off-by-one counter either raises done early or corrupts address 0 afterward.

// File: rtl/sop_array.sv
module sop_array #(
  parameter int NSIG    = 22,
  parameter int NOUT    = 10,
  parameter int MIN_PT  = 8,
  parameter int PT_STEP = 2,
  parameter int SIG_W   = 64,
  parameter int ADDR_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSIG-1:0]   sig_in,
  input  logic              load_start,
  input  logic              load_valid,
  input  logic              load_bit,
  input  logic              sec_set,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              load_done,
  output logic              rd_data,
  output logic [NOUT-1:0]   sum_out,
  output logic [NOUT-1:0]   oe_out,
  output logic              ar_term,
  output logic              sp_term,
  output logic [2*NOUT-1:0] mode_bits
);

  function automatic int pt_count(input int i);
    return (i < NOUT/2) ? MIN_PT + PT_STEP*i : MIN_PT + PT_STEP*(NOUT-1-i);
  endfunction

  function automatic int pt_base(input int i);
    int b = 1;
    for (int j = 0; j < i; j++) b += 1 + pt_count(j);
    return b;
  endfunction

  localparam int COLS      = 2*NSIG;
  localparam int NTERMS    = pt_base(NOUT) + 1;
  localparam int MODE_BASE = NTERMS*COLS;
  localparam int SIG_BASE  = MODE_BASE + 2*NOUT;
  localparam int TOTAL     = SIG_BASE + SIG_W;
  localparam int CW        = $clog2(TOTAL);
  localparam logic [CW-1:0]     CNT_LAST = CW'(TOTAL-1);
  localparam logic [ADDR_W-1:0] SIG_A    = ADDR_W'(SIG_BASE);
  localparam logic [ADDR_W-1:0] END_A    = ADDR_W'(TOTAL);

  logic [TOTAL-1:0] fuse;
  logic [COLS-1:0]  col;
  logic [NTERMS-1:0] pt;
  logic [CW-1:0]    cnt;
  logic             busy;
  logic             secure;

  for (genvar k = 0; k < NSIG; k++) begin : g_col
    assign col[2*k]   = sig_in[k];
    assign col[2*k+1] = ~sig_in[k];
  end

  for (genvar t = 0; t < NTERMS; t++) begin : g_pt
    assign pt[t] = &(col | ~fuse[t*COLS +: COLS]);
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam int B = pt_base(i);
    localparam int N = pt_count(i);
    assign oe_out[i]  = pt[B];
    assign sum_out[i] = |pt[B+1 +: N];
  end

  assign ar_term   = pt[0];
  assign sp_term   = pt[NTERMS-1];
  assign mode_bits = fuse[MODE_BASE +: 2*NOUT];

  always_comb begin
    if (rd_addr >= END_A)                rd_data = 1'b0;
    else if (secure && rd_addr < SIG_A)  rd_data = 1'b0;
    else                                 rd_data = fuse[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse      <= '1;
      cnt       <= '0;
      busy      <= 1'b0;
      load_done <= 1'b0;
      secure    <= 1'b0;
    end else if (load_start) begin
      cnt       <= '0;
      busy      <= 1'b1;
      load_done <= 1'b0;
      secure    <= 1'b0;
    end else begin
      if (busy && load_valid) begin
        fuse <= {load_bit, fuse[TOTAL-1:1]};
        cnt  <= cnt + 1'b1;
        if (cnt == CNT_LAST) begin
          busy      <= 1'b0;
          load_done <= 1'b1;
        end
      end
      if (sec_set) secure <= 1'b1;
    end
  end

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int FW       = 5892,
  parameter int SIG_BASE = 5828,
  parameter int COLS     = 44,
  parameter int ADDR_W   = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_start,
  input logic              load_done,
  input logic              secure,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_data,
  input logic              ar_term,
  input logic [FW-1:0]     fuse
);
  localparam logic [ADDR_W-1:0] SB = ADDR_W'(SIG_BASE);

  p_done_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_done && !load_start |=> load_done);

  p_frozen_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_done && !load_start |=> $stable(fuse));

  p_full_term_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&fuse[COLS-1:0]) |-> !ar_term);

  p_blocked_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    secure && rd_addr < SB |-> !rd_data);

  p_secure_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    secure && !load_start |=> secure);

  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> !load_done && !secure);
endmodule

bind sop_array sop_array_chk #(
  .FW(TOTAL), .SIG_BASE(SIG_BASE), .COLS(COLS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_done(load_done),
  .secure(secure), .rd_addr(rd_addr), .rd_data(rd_data), .ar_term(ar_term),
  .fuse(fuse)
);

// File: tb/sop_array_tb.sv
module sop_array_tb;
  localparam int CLK_P = 10;
  localparam int TOTAL = 5892;
  localparam int SIGB  = 5828;
  localparam int MODEB = 5808;
  localparam int NT    = 132;

  logic        clk = 0, rst_n = 0;
  logic [21:0] sig_in = '0;
  logic        load_start = 0, load_valid = 0, load_bit = 0, sec_set = 0;
  logic [12:0] rd_addr = '0;
  logic        load_done, rd_data, ar_term, sp_term;
  logic [9:0]  sum_out, oe_out;
  logic [19:0] mode_bits;

  logic [TOTAL-1:0] img;
  int checks = 0, fails = 0;
  int sizes [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  always #(CLK_P/2) clk = ~clk;

  sop_array u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int oe_idx(input int i);
    int b = 1;
    for (int j = 0; j < i; j++) b += 1 + sizes[j];
    return b;
  endfunction

  function automatic logic term(input int t, input logic [21:0] s);
    logic v = 1'b1;
    for (int c = 0; c < 44; c++)
      if (img[t*44 + c]) v &= (c % 2 == 0) ? s[c/2] : ~s[c/2];
    return v;
  endfunction

  task automatic fill_random();
    for (int t = 0; t < NT; t++) begin
      int ch = $urandom % 8;
      for (int c = 0; c < 44; c++) img[t*44 + c] = (ch < 5) ? 1'b0 : 1'b1;
      if (ch < 5) begin
        for (int n = 0; n < 1 + ($urandom % 3); n++) img[t*44 + ($urandom % 44)] = 1'b1;
      end else if (ch == 7 && ($urandom % 4 == 0)) begin
        for (int c = 0; c < 44; c++) img[t*44 + c] = 1'b0;
      end
    end
    for (int a = MODEB; a < TOTAL; a++) img[a] = 1'($urandom);
  endtask

  // boundary pattern: last logic term of output i follows sig i, enable follows ~sig(i+10)
  task automatic fill_edges();
    img = '1;
    for (int i = 0; i < 10; i++) begin
      int b = oe_idx(i);
      int lt = b + sizes[i];
      for (int c = 0; c < 44; c++) begin
        img[b*44 + c]  = 1'b0;
        img[lt*44 + c] = 1'b0;
      end
      img[lt*44 + 2*i]      = 1'b1;
      img[b*44 + 2*(i+10)+1] = 1'b1;
    end
  endtask

  task automatic load_img();
    @(negedge clk); load_start = 1;
    @(negedge clk); load_start = 0;
    for (int k = 0; k < TOTAL; k++) begin
      if ($urandom % 16 == 0) begin
        load_valid = 0; load_bit = 1'($urandom);
        @(negedge clk);
      end
      load_valid = 1; load_bit = img[k];
      if (k == TOTAL-1) chk(load_done == 1'b0, "R2 done early", load_done, 0);
      @(negedge clk);
    end
    load_valid = 0;
    chk(load_done == 1'b1, "R2 done after last bit", load_done, 1);
    for (int k = 0; k < 20; k++) begin
      load_valid = 1; load_bit = ~img[k];
      @(negedge clk);
    end
    load_valid = 0;
    for (int k = 0; k < 4; k++) begin
      rd_addr = 13'(k); #1;
      chk(rd_data == img[k], "R2 extra bits ignored", rd_data, img[k]);
    end
  endtask

  task automatic check_logic(input int n);
    for (int v = 0; v < n; v++) begin
      logic [9:0] es, eo;
      logic [19:0] em;
      @(negedge clk);
      sig_in = 22'($urandom);
      #1;
      for (int i = 0; i < 10; i++) begin
        int b = oe_idx(i);
        eo[i] = term(b, sig_in);
        es[i] = 1'b0;
        for (int j = 0; j < sizes[i]; j++) es[i] |= term(b + 1 + j, sig_in);
        em[2*i]   = img[MODEB + 2*i];
        em[2*i+1] = img[MODEB + 2*i + 1];
      end
      chk(sum_out == es, "R3/R4 sum terms", sum_out, es);
      chk(oe_out == eo, "R5 enable terms", oe_out, eo);
      chk({ar_term, sp_term} == {term(0, sig_in), term(NT-1, sig_in)}, "R6 global terms",
          {ar_term, sp_term}, {term(0, sig_in), term(NT-1, sig_in)});
      chk(mode_bits == em, "R7 mode bits", mode_bits, em);
    end
  endtask

  task automatic check_read(input bit prot);
    for (int n = 0; n < 300; n++) begin
      logic e;
      int a = (n < 64) ? SIGB + n : (n < 70) ? TOTAL + ($urandom % 300) : $urandom % TOTAL;
      rd_addr = 13'(a); #1;
      e = (a >= TOTAL) ? 1'b0 : (prot && a < SIGB) ? 1'b0 : img[a];
      if (prot) chk(rd_data == e, "R9 protected readback", rd_data, e);
      else      chk(rd_data == e, "R8 readback", rd_data, e);
    end
  endtask

  initial begin
    #(CLK_P*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    img = '1;
    #(CLK_P*3); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(sum_out == 0 && oe_out == 0, "R1 reset terms", {sum_out, oe_out}, 0);
    chk(ar_term == 0 && sp_term == 0, "R1 reset globals", {ar_term, sp_term}, 0);
    chk(mode_bits == '1, "R1 reset modes", mode_bits, 20'hfffff);
    rd_addr = 0; #1;
    chk(load_done == 0 && rd_data == 1, "R1 reset load state", {load_done, rd_data}, 1);

    fill_edges();
    load_img();
    check_logic(80);
    check_read(0);

    for (int cfg = 0; cfg < 3; cfg++) begin
      fill_random();
      load_img();
      check_read(0);
      check_logic(150);
      @(negedge clk); sec_set = 1;
      @(negedge clk); sec_set = 0;
      check_read(1);
      check_logic(30);
    end

    // R10: a new load clears protection
    @(negedge clk); load_start = 1;
    @(negedge clk); load_start = 0;
    rd_addr = 13'd5; #1;
    chk(load_done == 0, "R10 done cleared", load_done, 0);
    chk(rd_data == img[5], "R10 protection cleared", rd_data, img[5]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule